// File: doc/BRIEF.md
# Addressed SPI Command Decoder

This block is the serial front end of a four-channel wiper register bank. It watches SCK, SI, chip select and HOLD on the system clock after synchronising them. It turns each framed SPI exchange into single-cycle requests for the bank. A frame opens when chip select falls. The first byte names a device type and a strapped slave address. The second byte carries an opcode, a data-register pointer and a wiper pointer. A third byte either carries write data from the host or returns read data to it.

The bank answers read requests through `rd_data` on the cycle after `req_valid`. The decoder shifts that byte out on `so`, MSB first, with each bit changing on falling SCK. `so_oe` is the enable for the tri-state pad: a low level means high impedance. After an increment/decrement instruction, every further rising SCK edge in the frame produces one step request. HOLD freezes the shift sequence without losing its place.

Top module: `spi_cmd_decoder`

## Requirements
- R1: After reset, a frame is accepted only after a falling edge of chip select has been seen. If `cs_n` is already low when reset is released, clocked bits cause no request until `cs_n` has gone high and then low again.
- R2: The first byte must equal {4'b0101, 2'b00, dev_addr}. On any mismatch the rest of the frame produces no request and leaves `so_oe` low.
- R3: Instruction byte bits [7:4] are the opcode, [3:2] the data-register pointer and [1:0] the wiper pointer. Opcode 1010 (write wiper) with exactly 24 bits yields request code 2 at chip-select rise, with the third byte on `req_data`.
- R4: Opcode 1100 (write data register) with exactly 24 bits yields request code 4 at chip-select rise, carrying both pointers and the third byte.
- R5: A write frame of any length other than 24 bits is discarded.
- R6: The transfer opcodes each yield one request at chip-select rise, only when exactly 16 bits were sent: 1101 gives code 5, 1110 code 6, 0001 code 7 and 1000 code 8.
- R7: Opcode 1001 (read wiper, code 1) and opcode 1011 (read data register, code 3) issue a request right after the 16th bit. The byte the bank returns appears on `so` in bits 17 to 24, MSB first, changing on falling SCK.
- R8: The instruction byte 8'h51 issues request code 9 and returns {7'b0, wip} on `so`.
- R9: Opcode 0010 enters step mode. Each later rising SCK edge in the frame yields code 10 (step up) when SI is 1 or code 11 (step down) when SI is 0, for the addressed wiper.
- R10: `so_oe` is low while chip select is high. An opcode outside the set above leaves `so_oe` low and gives no request.
- R11: When HOLD goes low while SCK is low, SCK edges are ignored and `so_oe` is low. When HOLD returns high while SCK is low, the frame resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low pause request |
| dev_addr | input | ADDR_W | Strapped slave address |
| wip | input | 1 | Write-in-progress flag returned by status reads |
| rd_data | input | 8 | Bank read data, valid the cycle after a read request |
| req_valid | output | 1 | One-cycle request strobe |
| req_op | output | 4 | Request code (see requirements) |
| req_wiper | output | 2 | Wiper pointer |
| req_dreg | output | 2 | Data-register pointer |
| req_data | output | 8 | Write data for write requests, zero otherwise |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for the SO pad; low means high impedance |

## Verification
The embedded properties check these rules on every cycle: writes and transfers leave only from frames of the right bit count, no request comes from a frame with a failed identification, step requests come only in step mode, and the SO enable stays off while deselected or paused. Only the bench scenarios can show the rest: that the right pointers and data reach the bank, that read bytes come out bit-exact and MSB first across a HOLD pause, and that a frame begun without a chip-select fall after reset is ignored.

// File: rtl/spi_dec_pkg.sv
package spi_dec_pkg;

    typedef enum logic [3:0] {
        OP_NONE     = 4'd0,
        OP_RD_WIPER = 4'd1,
        OP_WR_WIPER = 4'd2,
        OP_RD_DREG  = 4'd3,
        OP_WR_DREG  = 4'd4,
        OP_DR2W     = 4'd5,
        OP_W2DR     = 4'd6,
        OP_GDR2W    = 4'd7,
        OP_GW2DR    = 4'd8,
        OP_STATUS   = 4'd9,
        OP_STEP_UP  = 4'd10,
        OP_STEP_DN  = 4'd11,
        OP_STEPMODE = 4'd12
    } op_e;

    localparam logic [3:0] DEV_TYPE   = 4'b0101;
    localparam logic [7:0] STATUS_CMD = 8'h51;

    typedef struct packed {
        logic       valid;
        op_e        op;
        logic [1:0] wiper;
        logic [1:0] dreg;
        logic [7:0] data;
    } req_t;

    function automatic logic is_xfer(op_e op);
        return (op == OP_DR2W) || (op == OP_W2DR) || (op == OP_GDR2W) || (op == OP_GW2DR);
    endfunction

    function automatic logic is_write(op_e op);
        return (op == OP_WR_WIPER) || (op == OP_WR_DREG);
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], pin_in[b]};
        end
        assign pin_sync[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/spi_op_decode.sv
module spi_op_decode
    import spi_dec_pkg::*;
(
    input  logic [7:0] instr,
    output op_e        op
);
    always_comb begin
        case (instr[7:4])
            4'b1001: op = OP_RD_WIPER;
            4'b1010: op = OP_WR_WIPER;
            4'b1011: op = OP_RD_DREG;
            4'b1100: op = OP_WR_DREG;
            4'b1101: op = OP_DR2W;
            4'b1110: op = OP_W2DR;
            4'b0001: op = OP_GDR2W;
            4'b1000: op = OP_GW2DR;
            4'b0010: op = OP_STEPMODE;
            4'b0101: op = (instr == STATUS_CMD) ? OP_STATUS : OP_NONE;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
    import spi_dec_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              si,
    input  logic              cs_n,
    input  logic              hold_n,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              wip,
    input  logic [7:0]        rd_data,
    output logic              req_valid,
    output logic [3:0]        req_op,
    output logic [1:0]        req_wiper,
    output logic [1:0]        req_dreg,
    output logic [7:0]        req_data,
    output logic              so,
    output logic              so_oe
);
    localparam int BYTE_W  = 8;
    localparam int FRAME2  = 2 * BYTE_W;
    localparam int FRAME3  = 3 * BYTE_W;
    localparam int CNT_W   = $clog2(FRAME3) + 1;
    localparam int ID_PAD  = 4 - ADDR_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic              sck_prev;
        logic              cs_prev;
        logic              active;
        logic              paused;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              id_ok;
        logic [BYTE_W-1:0] instr;
        op_e               op;
        logic              step_mode;
        logic [1:0]        pend;
        logic              live;
        logic              drv;
        logic [BYTE_W-1:0] so_sh;
        logic              so_bit;
        logic              so_oe;
        req_t              req;
    } st_t;

    st_t q, d;

    logic [3:0]        pins_sync;
    logic              sck_l, si_l, cs_l, hold_l;
    logic [BYTE_W-1:0] sh_next;
    op_e               dec_op;
    logic              sck_rise, sck_fall, cs_rise, cs_fall;

    spi_pin_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   ({hold_n, cs_n, si, sck}),
        .pin_sync (pins_sync)
    );
    assign {hold_l, cs_l, si_l, sck_l} = pins_sync;

    assign sh_next  = {q.sh[BYTE_W-2:0], si_l};
    assign sck_rise =  sck_l & ~q.sck_prev;
    assign sck_fall = ~sck_l &  q.sck_prev;
    assign cs_rise  =  cs_l  & ~q.cs_prev;
    assign cs_fall  = ~cs_l  &  q.cs_prev;

    spi_op_decode u_dec (.instr(sh_next), .op(dec_op));

    function automatic req_t mk_req(op_e op, logic [BYTE_W-1:0] ins, logic [BYTE_W-1:0] dat);
        req_t r;
        r.valid = 1'b1;
        r.op    = op;
        r.wiper = ins[1:0];
        r.dreg  = ins[3:2];
        r.data  = dat;
        return r;
    endfunction

    always_comb begin
        d           = q;
        d.req.valid = 1'b0;
        d.sck_prev  = sck_l;
        d.cs_prev   = cs_l;
        if (cs_fall) begin
            d.active    = 1'b1;
            d.paused    = 1'b0;
            d.cnt       = '0;
            d.id_ok     = 1'b0;
            d.op        = OP_NONE;
            d.step_mode = 1'b0;
            d.pend      = '0;
            d.live      = 1'b0;
            d.drv       = 1'b0;
        end else if (cs_rise) begin
            if (q.active && q.id_ok) begin
                if (q.cnt == CNT_W'(FRAME3) && is_write(q.op))
                    d.req = mk_req(q.op, q.instr, q.sh);
                else if (q.cnt == CNT_W'(FRAME2) && is_xfer(q.op))
                    d.req = mk_req(q.op, q.instr, '0);
            end
            d.active    = 1'b0;
            d.paused    = 1'b0;
            d.step_mode = 1'b0;
            d.pend      = '0;
            d.live      = 1'b0;
            d.drv       = 1'b0;
        end else if (q.active) begin
            if (!sck_l) d.paused = ~hold_l;
            if (!q.paused && sck_rise) begin
                d.sh = sh_next;
                if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(BYTE_W - 1))
                    d.id_ok = (sh_next == {DEV_TYPE, {ID_PAD{1'b0}}, dev_addr});
                if (q.cnt == CNT_W'(FRAME2 - 1) && q.id_ok) begin
                    d.instr = sh_next;
                    d.op    = dec_op;
                    case (dec_op)
                        OP_RD_WIPER, OP_RD_DREG: begin
                            d.req  = mk_req(dec_op, sh_next, '0);
                            d.pend = 2'd2;
                        end
                        OP_STATUS: begin
                            d.req   = mk_req(dec_op, sh_next, '0);
                            d.so_sh = {{(BYTE_W-1){1'b0}}, wip};
                            d.live  = 1'b1;
                        end
                        OP_STEPMODE: d.step_mode = 1'b1;
                        default: ;
                    endcase
                end
                if (q.step_mode)
                    d.req = mk_req(si_l ? OP_STEP_UP : OP_STEP_DN, q.instr, '0);
            end
            if (!q.paused && sck_fall && q.live) begin
                d.so_bit = q.so_sh[BYTE_W-1];
                d.so_sh  = {q.so_sh[BYTE_W-2:0], 1'b0};
                d.drv    = 1'b1;
            end
            if (q.pend == 2'd1) begin
                d.so_sh = rd_data;
                d.live  = 1'b1;
            end
            if (q.pend != 2'd0) d.pend = q.pend - 1'b1;
        end
        d.so_oe = d.active & d.drv & ~d.paused;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.op     <= OP_NONE;
            q.req.op <= OP_NONE;
        end else begin
            q <= d;
        end
    end

    assign req_valid = q.req.valid;
    assign req_op    = q.req.op;
    assign req_wiper = q.req.wiper;
    assign req_dreg  = q.req.dreg;
    assign req_data  = q.req.data;
    assign so        = q.so_bit;
    assign so_oe     = q.so_oe;

    // R1, R2: no request of any kind without a matched identification byte
    assert_id_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(q.id_ok));

    // R5: write requests only from frames of exactly three bytes
    assert_write_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_write(op_e'(req_op))) |-> $past(q.cnt) == CNT_W'(FRAME3));

    // R6: transfer requests only from frames of exactly two bytes
    assert_xfer_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_xfer(op_e'(req_op))) |-> $past(q.cnt) == CNT_W'(FRAME2));

    // R9: step requests only while step mode was armed
    assert_step_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == OP_STEP_UP || req_op == OP_STEP_DN)) |-> $past(q.step_mode));

    // R10: pad released while deselected
    assert_so_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_l && q.cs_prev) |-> !so_oe);

    // R11: pad released while paused
    assert_pause_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.paused |-> !so_oe);

endmodule

// File: tb/spi_cmd_decoder_test.sv
module spi_cmd_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8 * CLK_PERIOD;
    localparam int GAP        = 12 * CLK_PERIOD;
    localparam logic [1:0] ADDR = 2'b10;
    localparam logic [7:0] ID_OK = {4'b0101, 2'b00, ADDR};

    logic clk = 0, rst_n = 0;
    logic sck = 0, si = 0, cs_n = 0, hold_n = 1, wip = 0;
    logic [1:0] dev_addr = ADDR;
    logic [7:0] rd_data = 0;
    logic       req_valid, so, so_oe;
    logic [3:0] req_op;
    logic [1:0] req_wiper, req_dreg;
    logic [7:0] req_data;

    int total = 0, bad = 0;
    logic [15:0] exp_q[$];
    logic        oe_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n), .hold_n(hold_n),
        .dev_addr(dev_addr), .wip(wip), .rd_data(rd_data),
        .req_valid(req_valid), .req_op(req_op), .req_wiper(req_wiper), .req_dreg(req_dreg),
        .req_data(req_data), .so(so), .so_oe(so_oe)
    );

    function automatic logic [7:0] reply(logic [3:0] op, logic [1:0] w, logic [1:0] dr);
        return {op, w, dr} ^ 8'hA5;
    endfunction

    // bank model: answers read requests on the following cycle
    always @(posedge clk)
        if (req_valid && (req_op == 4'd1 || req_op == 4'd3))
            rd_data <= reply(req_op, req_wiper, req_dreg);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_req(logic [3:0] op, logic [1:0] w, logic [1:0] dr, logic [7:0] dat);
        exp_q.push_back({op, w, dr, dat});
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (so_oe) oe_seen = 1'b1;
        if (rst_n && req_valid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R3-R9 unexpected request actual=%h expected=none",
                         {req_op, req_wiper, req_dreg, req_data});
            end else begin
                check("R3-R9 request fields", {16'h0, req_op, req_wiper, req_dreg, req_data},
                      {16'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic frame(input logic [31:0] bits, input int nbits, input logic no_fall,
                         input logic pause, output logic [7:0] rx);
        rx = 0;
        oe_seen = 0;
        if (!no_fall) cs_n = 0;
        #(HALF);
        for (int i = 0; i < nbits; i++) begin
            si = bits[31-i];
            #(HALF);
            if (i >= 16 && i < 24) rx = {rx[6:0], so};
            sck = 1;
            #(HALF);
            sck = 0;
            if (pause && i == 19) begin
                #(HALF);
                hold_n = 0;
                #(HALF);
                check("R11 so_oe during pause", {31'h0, so_oe}, 32'h0);
                for (int k = 0; k < 3; k++) begin
                    sck = 1; #(HALF); sck = 0; #(HALF);
                end
                hold_n = 1;
            end
        end
        #(HALF);
        cs_n = 1;
        #(GAP);
        check("R10 so_oe with cs high", {31'h0, so_oe}, 32'h0);
    endtask

    logic [7:0] rx;

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 4);
        rst_n = 1;
        #(CLK_PERIOD * 4);
        check("R1 reset req_valid", {31'h0, req_valid}, 32'h0);
        check("R1 reset so_oe", {31'h0, so_oe}, 32'h0);

        // R1: cs already low at reset release -> ignored
        frame({ID_OK, 8'hA1, 8'h3C, 8'h0}, 24, 1'b1, 1'b0, rx);
        // R2: bad type, bad address, nonzero upper address bits
        frame({8'h62, 8'hA1, 8'h3C, 8'h0}, 24, 1'b0, 1'b0, rx);
        frame({8'h51, 8'hA1, 8'h3C, 8'h0}, 24, 1'b0, 1'b0, rx);
        frame({8'h56, 8'hB2, 8'h00, 8'h0}, 24, 1'b0, 1'b0, rx);
        check("R2 so_oe after bad id read", {31'h0, oe_seen}, 32'h0);

        // R3 write wiper
        expect_req(4'd2, 2'd1, 2'd0, 8'h3C);
        frame({ID_OK, 8'hA1, 8'h3C, 8'h0}, 24, 1'b0, 1'b0, rx);
        // R4 write data register
        expect_req(4'd4, 2'd3, 2'd2, 8'hE7);
        frame({ID_OK, 8'hCB, 8'hE7, 8'h0}, 24, 1'b0, 1'b0, rx);
        // R5 short and long writes
        frame({ID_OK, 8'hA1, 8'h3C, 8'h0}, 23, 1'b0, 1'b0, rx);
        frame({ID_OK, 8'hC5, 8'h3C, 8'h0}, 25, 1'b0, 1'b0, rx);

        // R6 transfers
        expect_req(4'd5, 2'd2, 2'd1, 8'h00);
        frame({ID_OK, 8'hD6, 16'h0}, 16, 1'b0, 1'b0, rx);
        expect_req(4'd6, 2'd1, 2'd3, 8'h00);
        frame({ID_OK, 8'hED, 16'h0}, 16, 1'b0, 1'b0, rx);
        expect_req(4'd7, 2'd0, 2'd2, 8'h00);
        frame({ID_OK, 8'h18, 16'h0}, 16, 1'b0, 1'b0, rx);
        expect_req(4'd8, 2'd0, 2'd1, 8'h00);
        frame({ID_OK, 8'h84, 16'h0}, 16, 1'b0, 1'b0, rx);
        frame({ID_OK, 8'hD6, 16'h0}, 24, 1'b0, 1'b0, rx);   // R6 wrong length

        // R7 reads
        expect_req(4'd1, 2'd3, 2'd0, 8'h00);
        frame({ID_OK, 8'h93, 16'h0}, 24, 1'b0, 1'b0, rx);
        check("R7 read wiper byte on so", {24'h0, rx}, {24'h0, reply(4'd1, 2'd3, 2'd0)});
        expect_req(4'd3, 2'd2, 2'd3, 8'h00);
        frame({ID_OK, 8'hBE, 16'h0}, 24, 1'b0, 1'b0, rx);
        check("R7 read dreg byte on so", {24'h0, rx}, {24'h0, reply(4'd3, 2'd2, 2'd3)});

        // R8 status
        wip = 1;
        expect_req(4'd9, 2'd1, 2'd0, 8'h00);
        frame({ID_OK, 8'h51, 16'h0}, 24, 1'b0, 1'b0, rx);
        check("R8 status wip=1", {24'h0, rx}, 32'h01);
        wip = 0;
        expect_req(4'd9, 2'd1, 2'd0, 8'h00);
        frame({ID_OK, 8'h51, 16'h0}, 24, 1'b0, 1'b0, rx);
        check("R8 status wip=0", {24'h0, rx}, 32'h00);

        // R9 step mode on wiper 1: up, up, down, up
        expect_req(4'd10, 2'd1, 2'd0, 8'h00);
        expect_req(4'd10, 2'd1, 2'd0, 8'h00);
        expect_req(4'd11, 2'd1, 2'd0, 8'h00);
        expect_req(4'd10, 2'd1, 2'd0, 8'h00);
        frame({ID_OK, 8'h21, 4'b1101, 12'h0}, 20, 1'b0, 1'b0, rx);

        // R10 unknown opcode
        frame({ID_OK, 8'h73, 8'h55, 8'h0}, 24, 1'b0, 1'b0, rx);
        check("R10 so_oe for unknown opcode", {31'h0, oe_seen}, 32'h0);

        // R11 pause in the middle of a read
        expect_req(4'd3, 2'd0, 2'd1, 8'h00);
        frame({ID_OK, 8'hB4, 16'h0}, 24, 1'b0, 1'b1, rx);
        check("R11 read byte across pause", {24'h0, rx}, {24'h0, reply(4'd3, 2'd0, 2'd1)});
        // R11 pause inside a write keeps bit count
        expect_req(4'd2, 2'd2, 2'd0, 8'h9A);
        frame({ID_OK, 8'hA2, 8'h9A, 8'h0}, 24, 1'b0, 1'b1, rx);

        #(GAP);
        check("R3-R9 scoreboard drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule